// File: doc/BRIEF.md
# Prioritized Address Region Decoder

This block takes each transfer a bus master issues and works out which single memory region should serve it. It holds ten programmable regions: eight device-select regions and, below them in priority, two DRAM bank regions. Each region has a base address and a mask. A transfer hits a region when its address agrees with the base on every bit the mask leaves clear. DRAM banks add two further checks. The transfer direction must be enabled for the bank, and the transfer's privilege/space class must not be excluded by the bank's class masks. If no region accepts the transfer, it falls through quietly to a default region and no select line is raised.

Configuration comes in through a simple write port. The port chooses a region, one of its three fields (base, mask or control), and a data word. Decode results appear on registered outputs one clock after the request strobe: a one-hot device-select vector, a one-hot bank vector, a default-hit flag and the index of the winning region.

Top module: `addr_region_decoder`

## Requirements
- R1: When several device-select regions match, the one with the lowest index wins. Device-select regions use indices 0 to 7.
- R2: Any qualifying device-select region wins over both DRAM banks, and bank 0 (index 8) wins over bank 1 (index 9).
- R3: An address matches a region when, for every bit where the mask is 0, the address bit equals the base bit. Mask bits that are 1 are ignored.
- R4: A region whose control bit 0 (valid) is clear never matches, whatever its base and mask hold.
- R5: A DRAM bank accepts reads only if control bit 1 is set, and accepts writes only if control bit 2 is set.
- R6: A DRAM bank rejects a transfer whose class mask bit is set. The class mask bits are control bit 3 for supervisor data, bit 4 for supervisor code, bit 5 for user data and bit 6 for user code.
- R7: A transfer that no region accepts raises only `dflt_hit`, leaves `cs_sel` and `bank_sel` at zero, and reports `hit_idx` = 10.
- R8: Outputs are registered. `out_valid` follows `req_valid` one cycle later, and exactly one of the select bits or `dflt_hit` is set while `out_valid` is high. With no request, all outputs are zero. A configuration write takes effect from the next cycle onward.
- R9: After reset every region is invalid and all outputs are zero, so every request decodes to the default region.
- R10: `hit_idx` gives the winner's index: 0 to 7 for device selects, 8 and 9 for banks, 10 for the default region. The field select `cfg_field` uses 0 for base, 1 for mask and 2 for control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Region index, 0 to 9 |
| cfg_field | input | 2 | Field select: 0 base, 1 mask, 2 control |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Transfer request strobe |
| req_addr | input | 32 | Transfer address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_super | input | 1 | 1 for supervisor, 0 for user |
| req_code | input | 1 | 1 for code space, 0 for data space |
| out_valid | output | 1 | Registered decode result valid |
| cs_sel | output | 8 | One-hot device-select vector |
| bank_sel | output | 2 | One-hot DRAM bank vector |
| dflt_hit | output | 1 | Default region taken |
| hit_idx | output | 4 | Index of the winning region |

## Verification
The bench targets regions that overlap. Two device selects cover the same address, a device select covers a bank, and both banks cover the same range. A design with a reversed or broken priority chain would raise the wrong select line or more than one. It also sends writes to a read-only bank and user transfers to a supervisor-only bank. A design that skipped the direction or class checks would select the bank there instead of falling to the default. Other cases cover a region cleared back to invalid, an address one bit past a region's size, and a configuration write in the same cycle as a request. These catch a valid bit that is ignored, a mask applied inverted, and a write that reaches the decoder a cycle too early.

// File: rtl/addr_region_decoder.sv
module addr_region_decoder #(
  parameter int AW    = 32,
  parameter int NCS   = 8,
  parameter int NBANK = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [$clog2(NCS+NBANK+1)-1:0]       cfg_idx,
  input  logic [1:0]                           cfg_field,
  input  logic [AW-1:0]                        cfg_wdata,
  input  logic                                 req_valid,
  input  logic [AW-1:0]                        req_addr,
  input  logic                                 req_write,
  input  logic                                 req_super,
  input  logic                                 req_code,
  output logic                                 out_valid,
  output logic [NCS-1:0]                       cs_sel,
  output logic [NBANK-1:0]                     bank_sel,
  output logic                                 dflt_hit,
  output logic [$clog2(NCS+NBANK+1)-1:0]       hit_idx
);
  localparam int NREG = NCS + NBANK;
  localparam int IW   = $clog2(NREG + 1);
  localparam int CW   = 7;
  localparam int DFLT = NREG;

  logic [AW-1:0] base_q [NREG];
  logic [AW-1:0] mask_q [NREG];
  logic [CW-1:0] ctl_q  [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        ctl_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NREG; i++) begin
        if (cfg_idx == IW'(i)) begin
          case (cfg_field)
            2'd0:    base_q[i] <= cfg_wdata;
            2'd1:    mask_q[i] <= cfg_wdata;
            2'd2:    ctl_q[i]  <= cfg_wdata[CW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  logic [1:0]      cls;
  logic [NREG-1:0] qual;
  assign cls = {~req_super, req_code};

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic addr_ok;
    assign addr_ok = (((req_addr ^ base_q[g]) & ~mask_q[g]) == '0);
    if (g < NCS) begin : g_cs
      assign qual[g] = ctl_q[g][0] & addr_ok;
    end else begin : g_bank
      logic       dir_ok;
      logic [3:0] cmask;
      assign dir_ok  = req_write ? ctl_q[g][2] : ctl_q[g][1];
      assign cmask   = ctl_q[g][6:3];
      assign qual[g] = ctl_q[g][0] & addr_ok & dir_ok & ~cmask[cls];
    end
  end

  logic [IW-1:0] win_idx;
  always_comb begin
    win_idx = IW'(DFLT);
    for (int i = NREG - 1; i >= 0; i--)
      if (qual[i]) win_idx = IW'(i);
  end

  logic [NREG-1:0] sel_q;
  logic            vld_q;
  logic [IW-1:0]   idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= '0;
      idx_q <= '0;
    end else begin
      vld_q <= req_valid;
      sel_q <= req_valid ? (qual & (~qual + 1'b1)) : '0;
      idx_q <= req_valid ? win_idx : '0;
    end
  end

  assign out_valid = vld_q;
  assign cs_sel    = sel_q[NCS-1:0];
  assign bank_sel  = sel_q[NREG-1:NCS];
  assign dflt_hit  = vld_q & ~|sel_q;
  assign hit_idx   = idx_q;

  p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({cs_sel, bank_sel, dflt_hit}) == 1);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ({cs_sel, bank_sel, dflt_hit} == '0 && hit_idx == '0));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(req_valid));

  p_dflt_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_hit |-> hit_idx == IW'(DFLT));

  p_index_matches_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dflt_hit) |-> ({bank_sel, cs_sel} == (NREG'(1) << hit_idx)));
endmodule

// File: tb/addr_region_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_region_decoder_tb_top;
  localparam int NCS = 8, NBANK = 2, NREG = 10, DFLT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [3:0] cfg_idx = 0; logic [1:0] cfg_field = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0; logic [31:0] req_addr = 0; logic req_write = 0, req_super = 0, req_code = 0;
  logic out_valid; logic [7:0] cs_sel; logic [1:0] bank_sel; logic dflt_hit; logic [3:0] hit_idx;

  always #2.5 clk = ~clk;

  addr_region_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_super(req_super), .req_code(req_code), .out_valid(out_valid), .cs_sel(cs_sel),
    .bank_sel(bank_sel), .dflt_hit(dflt_hit), .hit_idx(hit_idx));

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_base [NREG];
  logic [31:0] m_mask [NREG];
  logic [6:0]  m_ctl  [NREG];

  function automatic int ref_pick(logic [31:0] a, bit w, bit s, bit c);
    for (int r = 0; r < NREG; r++) begin
      if (!m_ctl[r][0]) continue;
      if (((a ^ m_base[r]) & ~m_mask[r]) != 0) continue;
      if (r >= NCS) begin
        if (w ? !m_ctl[r][2] : !m_ctl[r][1]) continue;
        if (m_ctl[r][3 + (s ? 0 : 2) + (c ? 1 : 0)]) continue;
      end
      return r;
    end
    return DFLT;
  endfunction

  task automatic compare(string tag, bit ev, logic [7:0] ecs, logic [1:0] eb, bit ed, logic [3:0] ei);
    n_tests++;
    if (out_valid !== ev || cs_sel !== ecs || bank_sel !== eb || dflt_hit !== ed || hit_idx !== ei) begin
      n_fail++;
      $display("FAIL %s: got v=%b cs=%h bank=%b dflt=%b idx=%0d, expected v=%b cs=%h bank=%b dflt=%b idx=%0d",
               tag, out_valid, cs_sel, bank_sel, dflt_hit, hit_idx, ev, ecs, eb, ed, ei);
    end
  endtask

  task automatic cyc(bit we, int ridx, int fld, logic [31:0] wd,
                     bit v, logic [31:0] a, bit w, bit s, bit c, string tag);
    int p;
    logic [7:0] ecs; logic [1:0] eb; bit ed; logic [3:0] ei;
    cfg_we = we; cfg_idx = 4'(ridx); cfg_field = 2'(fld); cfg_wdata = wd;
    req_valid = v; req_addr = a; req_write = w; req_super = s; req_code = c;
    p = v ? ref_pick(a, w, s, c) : -1;
    ecs = (v && p < NCS) ? (8'(1) << p) : 8'h0;
    eb  = (v && p >= NCS && p < NREG) ? (2'(1) << (p - NCS)) : 2'b0;
    ed  = v && (p == DFLT);
    ei  = v ? 4'(p) : 4'h0;
    if (we && ridx < NREG) begin
      if (fld == 0) m_base[ridx] = wd;
      else if (fld == 1) m_mask[ridx] = wd;
      else if (fld == 2) m_ctl[ridx] = wd[6:0];
    end
    @(posedge clk); @(negedge clk);
    compare(tag, v, ecs, eb, ed, ei);
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(int r, int f, logic [31:0] d, string tag);
    cyc(1, r, f, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rq(logic [31:0] a, bit w, bit s, bit c, string tag);
    cyc(0, 0, 0, 0, 1, a, w, s, c, tag);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin m_base[r] = 0; m_mask[r] = 0; m_ctl[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    compare("R9 reset outputs", 0, 8'h0, 2'b0, 0, 4'h0);
    rq(32'h0, 0, 1, 0, "R9 unprogrammed to default");
    rq(32'h0400_0000, 1, 0, 1, "R9 unprogrammed to default");

    wr(8, 0, 32'h0400_0000, "R8 idle during cfg");
    wr(8, 1, 32'h00FF_FFFF, "R8 idle during cfg");
    wr(8, 2, 32'h0000_0067, "R8 idle during cfg");
    wr(9, 0, 32'h0500_0000, "R8 idle during cfg");
    wr(9, 1, 32'h000F_FFFF, "R8 idle during cfg");
    wr(9, 2, 32'h0000_0003, "R8 idle during cfg");

    rq(32'h0400_0000, 0, 0, 0, "R6 user data read to supervisor-only bank");
    rq(32'h0400_0010, 0, 1, 0, "R5 supervisor data read bank0");
    rq(32'h04FF_FFFC, 1, 1, 1, "R3 supervisor code write top of bank0");
    rq(32'h0400_0000, 0, 0, 1, "R6 user code read to default");
    rq(32'h0500_0000, 1, 0, 0, "R5 write to read-only bank");
    rq(32'h0500_0004, 0, 0, 0, "R5 user read bank1");
    rq(32'h0510_0000, 0, 1, 0, "R3 one past bank1 size");
    rq(32'h0600_0000, 0, 1, 0, "R7 unmapped to default");

    wr(3, 0, 32'h0400_0000, "R8 idle during cfg");
    wr(3, 1, 32'h0000_FFFF, "R8 idle during cfg");
    rq(32'h0400_0020, 0, 1, 0, "R4 cs3 not yet valid");
    wr(3, 2, 32'h0000_0001, "R8 idle during cfg");
    rq(32'h0400_0020, 0, 1, 0, "R2 cs3 beats bank0");
    rq(32'h0401_0000, 0, 1, 0, "R3 beyond cs3 mask to bank0");
    wr(1, 0, 32'h0400_0000, "R8 idle during cfg");
    wr(1, 1, 32'h000F_FFFF, "R8 idle during cfg");
    cyc(1, 1, 2, 32'h1, 1, 32'h0400_0020, 0, 1, 0, "R8 same-cycle cfg uses old state");
    rq(32'h0400_0020, 0, 1, 0, "R1 cs1 beats cs3");
    rq(32'h0408_0000, 1, 0, 0, "R1 cs1 only");
    wr(1, 2, 32'h0000_0000, "R8 idle during cfg");
    rq(32'h0400_0020, 0, 1, 0, "R4 cs1 invalidated");

    wr(9, 0, 32'h0400_0000, "R8 idle during cfg");
    wr(9, 1, 32'h00FF_FFFF, "R8 idle during cfg");
    wr(9, 2, 32'h0000_0007, "R8 idle during cfg");
    rq(32'h0480_0000, 0, 1, 0, "R2 bank0 beats bank1");
    rq(32'h0480_0000, 1, 0, 0, "R6 user write falls to bank1");
    rq(32'h0480_0000, 1, 0, 1, "R10 user code write bank1 index");

    for (int k = 0; k < 60; k++)
      rq(32'h0400_0000 | ($urandom & 32'h01FF_FFFF), 1'($urandom), 1'($urandom), 1'($urandom),
         "R10 random sweep");
    for (int k = 0; k < 3; k++)
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle quiet");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule